// File: doc/BRIEF.md
# First-Hit Strip Address Selector

Each crossing of the accelerator clock, every front-end chip that saw activity reports one thing: the address of the strip that fired first among its 64 channels. This block collects those reports from all 32 chips and picks which of them go out on the trigger link. The link frame has room for only a few hits.

The block fills the output frame from the lowest chip index upward. Each entry is tagged with its chip index, so the receiver can rebuild the full strip coordinate. When more chips report than the frame can hold, the higher-indexed chips are dropped and a flag marks that crossing. The block takes a new set of inputs on every clock and delivers the matching frame one clock later. It therefore keeps pace with one crossing per clock.

Top module: `hitsel_top`

## Requirements
- R1: While reset is asserted and in the first output after it, every slot valid bit is 0, every slot address is 0 and the overflow flag is 0.
- R2: The frame built from the inputs sampled at one rising clock edge appears on the outputs right after the next rising edge. There is exactly one cycle of latency, and a new input set is accepted on every cycle.
- R3: Slot k carries the hit of the (k+1)-th lowest-indexed chip whose valid input is high, so chip indices increase strictly from slot to slot.
- R4: A slot address is 11 bits. Bits 10:6 hold the 5-bit chip index and bits 5:0 hold that chip's 6-bit strip address.
- R5: The valid bits fill from slot 0 upward with no gaps. The number of valid slots is the smaller of the number of reporting chips and 8.
- R6: A slot whose valid bit is 0 carries address 0.
- R7: The overflow flag is 1 exactly when more than 8 chips report in the crossing. The hits of chips beyond the eighth reporting chip are discarded.
- R8: The strip address input of a chip whose valid input is 0 has no effect on any output.
- R9: When exactly 8 chips report, all 8 slots are valid and the overflow flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_hit | input | 32 | Bit i is high when chip i reports a hit |
| chip_strip | input | 192 | Strip address of chip i in bits [6i+5:6i] |
| slot_valid | output | 8 | Bit k is high when slot k holds a hit |
| slot_addr | output | 88 | Slot k address in bits [11k+10:11k], formatted {chip, strip} |
| overflow | output | 1 | More than 8 chips reported in this crossing |

## Verification
The clocked properties assume that the hit inputs hold a defined value from the first edge after reset. They take no other assumption about the inputs: any pattern of reporting chips and any strip value is legal, including garbage on chips that do not report. The stimulus holds every input at zero during reset and drives new values only on falling edges. It covers empty and full crossings, the 8/9 boundary, single hits at the extreme chip indices and randomized densities both above and below the frame size.

// File: rtl/hitsel_pkg.sv
package hitsel_pkg;
   localparam int unsigned HS_CHIPS_DEF   = 32;
   localparam int unsigned HS_STRIP_W_DEF = 6;
   localparam int unsigned HS_SLOTS_DEF   = 8;

   function automatic int unsigned hs_min(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/hitsel_rank.sv
module hitsel_rank #(
   parameter int unsigned NUM_CHIPS = hitsel_pkg::HS_CHIPS_DEF,
   localparam int unsigned RANK_W   = $clog2(NUM_CHIPS + 1)
) (
   input  logic [NUM_CHIPS-1:0]        hit_i,
   output logic [NUM_CHIPS*RANK_W-1:0] rank_o,
   output logic [RANK_W-1:0]           total_o
);
   logic [RANK_W-1:0] run [NUM_CHIPS+1];

   assign run[0] = '0;
   for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_run
      assign run[i+1] = run[i] + RANK_W'(hit_i[i]);
      assign rank_o[i*RANK_W +: RANK_W] = run[i];
   end
   assign total_o = run[NUM_CHIPS];
endmodule

// File: rtl/hitsel_slot.sv
module hitsel_slot #(
   parameter int unsigned NUM_CHIPS = hitsel_pkg::HS_CHIPS_DEF,
   parameter int unsigned STRIP_W   = hitsel_pkg::HS_STRIP_W_DEF,
   parameter int unsigned SLOT_IDX  = 0,
   localparam int unsigned CHIP_W   = $clog2(NUM_CHIPS),
   localparam int unsigned RANK_W   = $clog2(NUM_CHIPS + 1),
   localparam int unsigned HIT_W    = CHIP_W + STRIP_W
) (
   input  logic [NUM_CHIPS-1:0]         hit_i,
   input  logic [NUM_CHIPS*STRIP_W-1:0] strip_i,
   input  logic [NUM_CHIPS*RANK_W-1:0]  rank_i,
   output logic                         valid_o,
   output logic [HIT_W-1:0]             addr_o
);
   logic [NUM_CHIPS-1:0] pick;
   logic [HIT_W-1:0]     term [NUM_CHIPS];
   logic [HIT_W-1:0]     acc  [NUM_CHIPS+1];

   assign acc[0] = '0;
   for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_pick
      assign pick[i] = hit_i[i] && (rank_i[i*RANK_W +: RANK_W] == RANK_W'(SLOT_IDX));
      assign term[i] = pick[i] ? {CHIP_W'(i), strip_i[i*STRIP_W +: STRIP_W]} : '0;
      assign acc[i+1] = acc[i] | term[i];
   end

   assign valid_o = |pick;
   assign addr_o  = acc[NUM_CHIPS];
endmodule

// File: rtl/hitsel_top.sv
module hitsel_top #(
   parameter int unsigned NUM_CHIPS = hitsel_pkg::HS_CHIPS_DEF,
   parameter int unsigned STRIP_W   = hitsel_pkg::HS_STRIP_W_DEF,
   parameter int unsigned MAX_SEL   = hitsel_pkg::HS_SLOTS_DEF,
   localparam int unsigned CHIP_W   = $clog2(NUM_CHIPS),
   localparam int unsigned RANK_W   = $clog2(NUM_CHIPS + 1),
   localparam int unsigned HIT_W    = CHIP_W + STRIP_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_CHIPS-1:0]         chip_hit,
   input  logic [NUM_CHIPS*STRIP_W-1:0] chip_strip,
   output logic [MAX_SEL-1:0]           slot_valid,
   output logic [MAX_SEL*HIT_W-1:0]     slot_addr,
   output logic                         overflow
);
   if (NUM_CHIPS < 2) begin : g_bad_chips
      $error("hitsel_top: NUM_CHIPS must be at least 2");
   end
   if (MAX_SEL < 1 || MAX_SEL > NUM_CHIPS) begin : g_bad_slots
      $error("hitsel_top: MAX_SEL must lie in 1..NUM_CHIPS");
   end
   if (STRIP_W < 1) begin : g_bad_strip
      $error("hitsel_top: STRIP_W must be positive");
   end

   logic [NUM_CHIPS*RANK_W-1:0] rank;
   logic [RANK_W-1:0]           total;
   logic [MAX_SEL-1:0]          nxt_valid;
   logic [MAX_SEL*HIT_W-1:0]    nxt_addr;
   logic                        nxt_ovf;

   hitsel_rank #(.NUM_CHIPS(NUM_CHIPS)) u_rank (
      .hit_i   (chip_hit),
      .rank_o  (rank),
      .total_o (total)
   );

   for (genvar k = 0; k < MAX_SEL; k++) begin : g_slot
      hitsel_slot #(
         .NUM_CHIPS (NUM_CHIPS),
         .STRIP_W   (STRIP_W),
         .SLOT_IDX  (k)
      ) u_slot (
         .hit_i   (chip_hit),
         .strip_i (chip_strip),
         .rank_i  (rank),
         .valid_o (nxt_valid[k]),
         .addr_o  (nxt_addr[k*HIT_W +: HIT_W])
      );
   end

   if (MAX_SEL == NUM_CHIPS) begin : g_no_ovf
      assign nxt_ovf = 1'b0;
   end else begin : g_ovf
      assign nxt_ovf = (total > RANK_W'(MAX_SEL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_valid <= '0;
         slot_addr  <= '0;
         overflow   <= 1'b0;
      end else begin
         slot_valid <= nxt_valid;
         slot_addr  <= nxt_addr;
         overflow   <= nxt_ovf;
      end
   end
endmodule

// File: rtl/hitsel_chk.sv
module hitsel_chk #(
   parameter int unsigned NUM_CHIPS = hitsel_pkg::HS_CHIPS_DEF,
   parameter int unsigned STRIP_W   = hitsel_pkg::HS_STRIP_W_DEF,
   parameter int unsigned MAX_SEL   = hitsel_pkg::HS_SLOTS_DEF,
   localparam int unsigned CHIP_W   = $clog2(NUM_CHIPS),
   localparam int unsigned HIT_W    = CHIP_W + STRIP_W
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_CHIPS-1:0]         chip_hit,
   input logic [MAX_SEL-1:0]           slot_valid,
   input logic [MAX_SEL*HIT_W-1:0]     slot_addr,
   input logic                         overflow
);
   // R5: valid bits form a contiguous run from slot 0
   a_r5_no_gaps: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_valid & (slot_valid + 1'b1)) == '0));

   // R5 / R2: count of valid slots follows the previous crossing's reports
   a_r5_count_below: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(chip_hit) < MAX_SEL) |=>
         ($countones(slot_valid) == $past($countones(chip_hit))));

   a_r5_count_full: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(chip_hit) >= MAX_SEL) |=> (&slot_valid));

   // R7: overflow only when too many chips report
   a_r7_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(chip_hit) > MAX_SEL) |=> overflow);

   // R9 / R7: no overflow at or below the frame size
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(chip_hit) <= MAX_SEL) |=> !overflow);

   for (genvar k = 0; k < MAX_SEL; k++) begin : g_slot_chk
      // R6: an empty slot carries a zero address
      a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !slot_valid[k] |-> (slot_addr[k*HIT_W +: HIT_W] == '0));
      if (k > 0) begin : g_order
         // R3: chip indices increase strictly across valid slots
         a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[k] |->
               (slot_addr[k*HIT_W + STRIP_W +: CHIP_W] >
                slot_addr[(k-1)*HIT_W + STRIP_W +: CHIP_W]));
      end
   end
endmodule

bind hitsel_top hitsel_chk #(
   .NUM_CHIPS (NUM_CHIPS),
   .STRIP_W   (STRIP_W),
   .MAX_SEL   (MAX_SEL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_hit   (chip_hit),
   .slot_valid (slot_valid),
   .slot_addr  (slot_addr),
   .overflow   (overflow)
);

// File: tb/hitsel_top_tb.sv
module hitsel_top_tb_top;
   localparam int NC = 32;
   localparam int SW = 6;
   localparam int MS = 8;
   localparam int HW = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NC-1:0]     chip_hit = '0;
   logic [NC*SW-1:0]  chip_strip = '0;
   logic [MS-1:0]     slot_valid;
   logic [MS*HW-1:0]  slot_addr;
   logic              overflow;

   int n_vec = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   hitsel_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_hit   (chip_hit),
      .chip_strip (chip_strip),
      .slot_valid (slot_valid),
      .slot_addr  (slot_addr),
      .overflow   (overflow)
   );

   task automatic compare(input logic [MS-1:0] ev, input logic [MS*HW-1:0] ea,
                          input logic eo, input string tag);
      n_vec++;
      if (slot_valid !== ev) begin
         n_bad++;
         $display("FAIL %s (R5) slot_valid actual=%b expected=%b", tag, slot_valid, ev);
      end
      if (slot_addr !== ea) begin
         n_bad++;
         $display("FAIL %s (R3/R4/R6) slot_addr actual=%h expected=%h", tag, slot_addr, ea);
      end
      if (overflow !== eo) begin
         n_bad++;
         $display("FAIL %s (R7) overflow actual=%b expected=%b", tag, overflow, eo);
      end
   endtask

   // Behavioural reference: list reporting chips in index order, keep the first MS.
   task automatic apply(input logic [NC-1:0] v, input logic [NC*SW-1:0] a, input string tag);
      int q[$];
      logic [MS-1:0]    ev;
      logic [MS*HW-1:0] ea;
      logic             eo;
      @(negedge clk);
      chip_hit   = v;
      chip_strip = a;
      for (int i = 0; i < NC; i++) if (v[i]) q.push_back(i);
      ev = '0; ea = '0;
      for (int k = 0; k < MS; k++) begin
         if (k < q.size()) begin
            ev[k] = 1'b1;
            ea[k*HW +: HW] = {5'(q[k]), a[q[k]*SW +: SW]};
         end
      end
      eo = (q.size() > MS);
      @(posedge clk);
      #1;
      compare(ev, ea, eo, tag);
   endtask

   function automatic logic [NC*SW-1:0] rnd_strips();
      logic [NC*SW-1:0] r;
      for (int i = 0; i < NC; i++) r[i*SW +: SW] = 6'($urandom);
      return r;
   endfunction

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog expired (R2) actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [NC*SW-1:0] s;
      repeat (3) @(negedge clk);
      compare('0, '0, 1'b0, "R1 during reset");
      rst_n = 1'b1;
      #1;
      compare('0, '0, 1'b0, "R1 after release");

      apply('0, rnd_strips(), "R5 no hits");
      apply(32'h8000_0000, {6'h2a, 186'h0}, "R4 top chip only");
      apply(32'h0000_0001, {186'h0, 6'h3f}, "R4 chip zero");
      // R8: junk strip values on silent chips must not appear
      s = rnd_strips();
      apply(32'h0001_0000, s | ~({NC*SW{1'b0}}), "R8 silent chips junk");
      apply(32'h8421_8421, rnd_strips(), "R9 exactly eight");
      apply(32'h8421_8423, rnd_strips(), "R7 nine hits");
      apply('1, rnd_strips(), "R7 all chips");
      apply(32'hFF00_0000, rnd_strips(), "R3 top eight");
      apply(32'h0000_00FF, rnd_strips(), "R9 bottom eight");
      apply(32'h0000_01FF, rnd_strips(), "R7 bottom nine");
      // R2: back-to-back crossings each yield their own frame
      apply(32'h0000_0003, rnd_strips(), "R2 back to back a");
      apply(32'hC000_0000, rnd_strips(), "R2 back to back b");
      apply('0, '0, "R6 return to empty");

      for (int n = 0; n < 400; n++) begin
         logic [NC-1:0] v;
         v = $urandom;
         case (n % 4)
            0: v = v & $urandom & $urandom;
            1: v = v & $urandom;
            2: v = v;
            default: v = v | $urandom;
         endcase
         apply(v, rnd_strips(), "R3 random");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule